// File: doc/BRIEF.md
# Unified Micro-Op Scheduler

This block is the shared scheduling buffer that sits between the allocator and six typed execution ports. Each cycle it accepts a group of up to four decoded micro-ops. Each op carries a class code, two source tags with ready flags and a destination tag. The op waits in one of 32 entries until both of its operands are available. A result broadcast of up to three tags per cycle wakes waiting operands. Ops whose operands are all available are handed to the execution ports, with at most one op per port per cycle.

The ports are not alike. Simple integer work has two ports to choose from, complex integer work has one, floating point has three, and the three memory kinds each have a dedicated port. When several ready ops compete for a port, the one allocated earliest wins. The block also counts micro-ops in flight, which means accepted and not yet retired. It tells the allocator to hold off when a full group could break the in-flight ceiling or could not find space in the buffer. A flush empties the buffer and zeroes the count in one cycle.

Top module: `uop_rs`

## Requirements
- R1: When `stall_o` is low, every valid allocation slot is written into a free entry at the clock edge. Up to four ops are taken per cycle.
- R2: Class codes are 0 simple integer/SIMD, 1 complex integer, 2 floating point, 3 load, 4 store address and 5 store data. Class 3 issues only on port 2, class 4 only on port 3, class 5 only on port 4, and class 1 only on port 1.
- R3: Class 0 issues on port 0 or port 5. Port 0 takes the oldest eligible op, and port 5 is used only for the next one when port 0 is already taken.
- R4: Class 2 may issue on port 0, 1 or 5. The oldest ready class 0/2 op takes port 0. Port 1 then takes the oldest remaining class 1/2 op. Port 5 takes the oldest class 0/2 op left after that.
- R5: Among competing ready ops, the one allocated in an earlier cycle is older. Within one group, a lower slot index is older.
- R6: A broadcast tag that matches a waiting source sets its ready flag. An op issues in the cycle after its last operand is woken. A broadcast in the cycle an op is allocated also wakes it. A tag that does not match wakes nothing.
- R7: An issued op is removed in the cycle it issues and never issues again.
- R8: `stall_o` is high when the in-flight count exceeds 124 or fewer than four entries are free. While it is high, allocation slots are ignored.
- R9: `inflight_o` rises by the number of accepted ops and falls by `retire_cnt_i` each cycle. It never exceeds 128.
- R10: `flush_i` empties every entry and zeroes `inflight_o` at the next edge. Nothing issues afterwards until new ops arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Drop all entries and zero the in-flight count |
| alloc_valid_i | input | 4 | Per-slot op valid |
| alloc_cls_i | input | 4x3 | Per-slot class code |
| alloc_src_tag_i | input | 4x2x7 | Per-slot source tags |
| alloc_src_rdy_i | input | 4x2 | Per-slot source ready flags |
| alloc_dst_i | input | 4x7 | Per-slot destination tag |
| wb_valid_i | input | 3 | Broadcast lane valid |
| wb_tag_i | input | 3x7 | Broadcast tags |
| retire_cnt_i | input | 3 | Ops retired this cycle |
| stall_o | output | 1 | Allocator must hold its group |
| inflight_o | output | 8 | Micro-ops in flight |
| issue_valid_o | output | 6 | Per-port issue valid |
| issue_cls_o | output | 6x3 | Class of the issued op per port |
| issue_dst_o | output | 6x7 | Destination tag of the issued op per port |

## Verification
The bench places an older op in a high slot and a younger op in slot 0 of a later group. A scheduler that ranks by slot or by entry index would then send the younger op to port 0. It mixes floating point with complex integer ops to catch a wrong port precedence, which would starve port 1 or leave port 0 idle. It wakes the two operands of an op in separate cycles, and it wakes one op in the cycle it is allocated. A design with the wrong wake timing would issue early, issue late, or miss the wake. It also drives the in-flight count to exactly 124, 128 and 125 and fills all 32 entries. A design with an off-by-one limit would stall a group it could take or would accept one that breaks the ceiling.

// File: rtl/uop_rs_pkg.sv
package uop_rs_pkg;
  typedef enum logic [2:0] {
    OP_ALU  = 3'd0,
    OP_CPLX = 3'd1,
    OP_FP   = 3'd2,
    OP_LOAD = 3'd3,
    OP_STA  = 3'd4,
    OP_STD  = 3'd5
  } op_cls_e;

  localparam int NUM_PORTS = 6;

  // class served by each dedicated memory port (2..4)
  function automatic logic [2:0] ded_cls(input int port);
    case (port)
      2:       ded_cls = OP_LOAD;
      3:       ded_cls = OP_STA;
      default: ded_cls = OP_STD;
    endcase
  endfunction
endpackage

// File: rtl/uop_rs_slot_find.sv
module uop_rs_slot_find #(
  parameter int N_ENT = 32,
  parameter int K     = 4,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int CNT_W = $clog2(N_ENT + 1)
) (
  input  logic [N_ENT-1:0]           free_i,
  output logic [K-1:0][IDX_W-1:0]    idx_o,
  output logic [K-1:0]               ok_o,
  output logic [CNT_W-1:0]           free_cnt_o
);
  int unsigned seen;

  always_comb begin
    idx_o = '0;
    ok_o  = '0;
    seen  = 0;
    for (int i = 0; i < N_ENT; i++) begin
      if (free_i[i]) begin
        for (int k = 0; k < K; k++) begin
          if (seen == k) begin
            idx_o[k] = IDX_W'(i);
            ok_o[k]  = 1'b1;
          end
        end
        seen = seen + 1;
      end
    end
  end

  assign free_cnt_o = CNT_W'($countones(free_i));
endmodule

// File: rtl/uop_rs_age_pick.sv
module uop_rs_age_pick #(
  parameter int N_ENT = 32
) (
  input  logic [N_ENT-1:0]             req_i,
  input  logic [N_ENT-1:0][N_ENT-1:0]  older_i,  // [a][b]: a older than b
  output logic [N_ENT-1:0]             gnt_o
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic [N_ENT-1:0] beat;
    for (genvar j = 0; j < N_ENT; j++) begin : g_cmp
      assign beat[j] = req_i[j] & older_i[j][i];
    end
    assign gnt_o[i] = req_i[i] & ~|beat;
  end
endmodule

// File: rtl/uop_rs.sv
module uop_rs
  import uop_rs_pkg::*;
#(
  parameter int N_ENT        = 32,
  parameter int ALLOC_W      = 4,
  parameter int WB_W         = 3,
  parameter int TAG_W        = 7,
  parameter int NUM_SRC      = 2,
  parameter int MAX_INFLIGHT = 128,
  localparam int IDX_W  = $clog2(N_ENT),
  localparam int SLOT_W = (ALLOC_W > 1) ? $clog2(ALLOC_W) : 1,
  localparam int CNT_W  = $clog2(MAX_INFLIGHT + 1),
  localparam int RET_W  = $clog2(ALLOC_W + 1),
  localparam int FREE_W = $clog2(N_ENT + 1)
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       flush_i,
  input  logic [ALLOC_W-1:0]                         alloc_valid_i,
  input  logic [ALLOC_W-1:0][2:0]                    alloc_cls_i,
  input  logic [ALLOC_W-1:0][NUM_SRC-1:0][TAG_W-1:0] alloc_src_tag_i,
  input  logic [ALLOC_W-1:0][NUM_SRC-1:0]            alloc_src_rdy_i,
  input  logic [ALLOC_W-1:0][TAG_W-1:0]              alloc_dst_i,
  input  logic [WB_W-1:0]                            wb_valid_i,
  input  logic [WB_W-1:0][TAG_W-1:0]                 wb_tag_i,
  input  logic [RET_W-1:0]                           retire_cnt_i,
  output logic                                       stall_o,
  output logic [CNT_W-1:0]                           inflight_o,
  output logic [NUM_PORTS-1:0]                       issue_valid_o,
  output logic [NUM_PORTS-1:0][2:0]                  issue_cls_o,
  output logic [NUM_PORTS-1:0][TAG_W-1:0]            issue_dst_o
);
  // entry state
  logic [N_ENT-1:0]                       vld_q;
  logic [2:0]                             cls_q   [N_ENT];
  logic [NUM_SRC-1:0][TAG_W-1:0]          tag_q   [N_ENT];
  logic [NUM_SRC-1:0]                     rdy_q   [N_ENT];
  logic [TAG_W-1:0]                       dst_q   [N_ENT];
  logic [N_ENT-1:0][N_ENT-1:0]            older_q;
  logic [CNT_W-1:0]                       inflight_q;

  // free slot search
  logic [ALLOC_W-1:0][IDX_W-1:0] slot_idx;
  logic [ALLOC_W-1:0]            slot_ok;
  logic [FREE_W-1:0]             free_cnt;

  uop_rs_slot_find #(.N_ENT(N_ENT), .K(ALLOC_W)) u_find (
    .free_i     (~vld_q),
    .idx_o      (slot_idx),
    .ok_o       (slot_ok),
    .free_cnt_o (free_cnt)
  );

  logic accept;
  assign stall_o = (inflight_q > CNT_W'(MAX_INFLIGHT - ALLOC_W)) ||
                   (free_cnt < FREE_W'(ALLOC_W));
  assign accept  = ~stall_o;

  // wakeup match for resident sources and incoming sources
  logic [NUM_SRC-1:0]            wake   [N_ENT];
  logic [ALLOC_W-1:0][NUM_SRC-1:0] in_rdy;

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      wake[i] = '0;
      for (int s = 0; s < NUM_SRC; s++)
        for (int w = 0; w < WB_W; w++)
          if (wb_valid_i[w] && wb_tag_i[w] == tag_q[i][s]) wake[i][s] = 1'b1;
    end
    for (int k = 0; k < ALLOC_W; k++)
      for (int s = 0; s < NUM_SRC; s++) begin
        in_rdy[k][s] = alloc_src_rdy_i[k][s];
        for (int w = 0; w < WB_W; w++)
          if (wb_valid_i[w] && wb_tag_i[w] == alloc_src_tag_i[k][s]) in_rdy[k][s] = 1'b1;
      end
  end

  // allocation steering
  logic [N_ENT-1:0]  new_ent;
  logic [SLOT_W-1:0] new_slot [N_ENT];

  always_comb begin
    new_ent = '0;
    for (int i = 0; i < N_ENT; i++) new_slot[i] = '0;
    for (int k = 0; k < ALLOC_W; k++)
      if (accept && alloc_valid_i[k] && slot_ok[k]) begin
        new_ent[slot_idx[k]]  = 1'b1;
        new_slot[slot_idx[k]] = SLOT_W'(k);
      end
  end

  // class decode and readiness
  logic [N_ENT-1:0] rdy, is_alu, is_cplx, is_fp;
  logic [N_ENT-1:0] is_ded [2:4];

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      rdy[i]     = vld_q[i] & (&rdy_q[i]);
      is_alu[i]  = cls_q[i] == OP_ALU;
      is_cplx[i] = cls_q[i] == OP_CPLX;
      is_fp[i]   = cls_q[i] == OP_FP;
      for (int p = 2; p <= 4; p++) is_ded[p][i] = cls_q[i] == ded_cls(p);
    end
  end

  // port 0 -> port 1 -> port 5 precedence for shared classes
  logic [N_ENT-1:0] req_p0, req_p1, req_p5, gnt_p0, gnt_p1, gnt_p5;
  logic [N_ENT-1:0] gnt_ded [2:4];

  assign req_p0 = rdy & (is_alu | is_fp);
  assign req_p1 = rdy & (is_cplx | is_fp) & ~gnt_p0;
  assign req_p5 = rdy & (is_alu | is_fp) & ~gnt_p0 & ~gnt_p1;

  uop_rs_age_pick #(.N_ENT(N_ENT)) u_pick_p0 (.req_i(req_p0), .older_i(older_q), .gnt_o(gnt_p0));
  uop_rs_age_pick #(.N_ENT(N_ENT)) u_pick_p1 (.req_i(req_p1), .older_i(older_q), .gnt_o(gnt_p1));
  uop_rs_age_pick #(.N_ENT(N_ENT)) u_pick_p5 (.req_i(req_p5), .older_i(older_q), .gnt_o(gnt_p5));

  for (genvar p = 2; p <= 4; p++) begin : g_ded
    uop_rs_age_pick #(.N_ENT(N_ENT)) u_pick (
      .req_i   (rdy & is_ded[p]),
      .older_i (older_q),
      .gnt_o   (gnt_ded[p])
    );
  end

  logic [N_ENT-1:0] gnt_all [NUM_PORTS];
  logic [N_ENT-1:0] issued;

  assign gnt_all[0] = gnt_p0;
  assign gnt_all[1] = gnt_p1;
  assign gnt_all[2] = gnt_ded[2];
  assign gnt_all[3] = gnt_ded[3];
  assign gnt_all[4] = gnt_ded[4];
  assign gnt_all[5] = gnt_p5;
  assign issued     = gnt_p0 | gnt_p1 | gnt_p5 | gnt_ded[2] | gnt_ded[3] | gnt_ded[4];

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      issue_valid_o[p] = |gnt_all[p];
      issue_cls_o[p]   = '0;
      issue_dst_o[p]   = '0;
      for (int i = 0; i < N_ENT; i++)
        if (gnt_all[p][i]) begin
          issue_cls_o[p] = issue_cls_o[p] | cls_q[i];
          issue_dst_o[p] = issue_dst_o[p] | dst_q[i];
        end
    end
  end

  // occupancy and in-flight count
  logic [CNT_W-1:0] acc_cnt;
  assign acc_cnt    = accept ? CNT_W'($countones(alloc_valid_i)) : '0;
  assign inflight_o = inflight_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q      <= '0;
      inflight_q <= '0;
    end else if (flush_i) begin
      vld_q      <= '0;
      inflight_q <= '0;
    end else begin
      vld_q      <= (vld_q & ~issued) | new_ent;
      inflight_q <= inflight_q + acc_cnt - CNT_W'(retire_cnt_i);
    end
  end

  // payload and age matrix, valid-qualified so no reset needed
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < N_ENT; i++) begin
      if (new_ent[i]) begin
        cls_q[i] <= alloc_cls_i[new_slot[i]];
        tag_q[i] <= alloc_src_tag_i[new_slot[i]];
        rdy_q[i] <= in_rdy[new_slot[i]];
        dst_q[i] <= alloc_dst_i[new_slot[i]];
      end else begin
        rdy_q[i] <= rdy_q[i] | wake[i];
      end
      for (int j = 0; j < N_ENT; j++) begin
        if (new_ent[i] && new_ent[j]) older_q[i][j] <= new_slot[i] < new_slot[j];
        else if (new_ent[i])          older_q[i][j] <= 1'b0;
        else if (new_ent[j])          older_q[i][j] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uop_rs_chk.sv
module uop_rs_chk
  import uop_rs_pkg::*;
#(
  parameter int ALLOC_W      = 4,
  parameter int TAG_W        = 7,
  parameter int MAX_INFLIGHT = 128,
  localparam int CNT_W = $clog2(MAX_INFLIGHT + 1)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          flush_i,
  input logic                          stall_o,
  input logic [CNT_W-1:0]              inflight_o,
  input logic [NUM_PORTS-1:0]          issue_valid_o,
  input logic [NUM_PORTS-1:0][2:0]     issue_cls_o,
  input logic [NUM_PORTS-1:0][TAG_W-1:0] issue_dst_o
);
  // R10
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (inflight_o == '0 && issue_valid_o == '0));

  // R8
  limit_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inflight_o > CNT_W'(MAX_INFLIGHT - ALLOC_W)) |-> stall_o);

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !flush_i) |=> (inflight_o <= $past(inflight_o)));

  // R9
  inflight_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_o <= CNT_W'(MAX_INFLIGHT));

  // R2
  load_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o[2] |-> issue_cls_o[2] == OP_LOAD);

  // R2
  cplx_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o[1] |-> (issue_cls_o[1] == OP_CPLX || issue_cls_o[1] == OP_FP));

  // R3
  p5_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o[5] |-> issue_valid_o[0]);

  // R3
  p5_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o[5] |-> (issue_cls_o[5] == OP_ALU || issue_cls_o[5] == OP_FP));
endmodule

bind uop_rs uop_rs_chk #(
  .ALLOC_W(ALLOC_W), .TAG_W(TAG_W), .MAX_INFLIGHT(MAX_INFLIGHT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .stall_o(stall_o),
  .inflight_o(inflight_o), .issue_valid_o(issue_valid_o),
  .issue_cls_o(issue_cls_o), .issue_dst_o(issue_dst_o)
);

// File: tb/uop_rs_tb_top.sv
`timescale 1ns/1ps
module uop_rs_tb_top;
  localparam int TAG_W = 7;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i;
  logic [3:0]                  alloc_valid_i;
  logic [3:0][2:0]             alloc_cls_i;
  logic [3:0][1:0][TAG_W-1:0]  alloc_src_tag_i;
  logic [3:0][1:0]             alloc_src_rdy_i;
  logic [3:0][TAG_W-1:0]       alloc_dst_i;
  logic [2:0]                  wb_valid_i;
  logic [2:0][TAG_W-1:0]       wb_tag_i;
  logic [2:0]                  retire_cnt_i;
  logic                        stall_o;
  logic [7:0]                  inflight_o;
  logic [5:0]                  issue_valid_o;
  logic [5:0][2:0]             issue_cls_o;
  logic [5:0][TAG_W-1:0]       issue_dst_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  uop_rs dut_i (.*);

  task automatic chk_eq(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic chk_port(string rq, int p, bit v, int dst);
    chk_eq(rq, $sformatf("port%0d valid", p), int'(issue_valid_o[p]), int'(v));
    if (v) chk_eq(rq, $sformatf("port%0d dst", p), int'(issue_dst_o[p]), dst);
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic clear_in();
    flush_i = 0; alloc_valid_i = '0; alloc_cls_i = '0; alloc_src_tag_i = '0;
    alloc_src_rdy_i = '0; alloc_dst_i = '0; wb_valid_i = '0; wb_tag_i = '0;
    retire_cnt_i = '0;
  endtask

  task automatic set_op(int k, int cls, int dst, int t0, bit r0, int t1, bit r1);
    alloc_valid_i[k] = 1'b1;
    alloc_cls_i[k] = 3'(cls);
    alloc_dst_i[k] = TAG_W'(dst);
    alloc_src_tag_i[k][0] = TAG_W'(t0); alloc_src_rdy_i[k][0] = r0;
    alloc_src_tag_i[k][1] = TAG_W'(t1); alloc_src_rdy_i[k][1] = r1;
  endtask

  task automatic do_flush();
    clear_in(); flush_i = 1; step(); flush_i = 0;
  endtask

  task automatic t_reset();
    chk_eq("R10", "reset stall", int'(stall_o), 0);
    chk_eq("R9", "reset inflight", int'(inflight_o), 0);
    chk_eq("R10", "reset issue", int'(issue_valid_o), 0);
  endtask

  task automatic t_dedicated();
    clear_in();
    set_op(0, 3, 11, 0, 1, 0, 1);
    set_op(1, 4, 12, 0, 1, 0, 1);
    set_op(2, 5, 13, 0, 1, 0, 1);
    set_op(3, 1, 14, 0, 1, 0, 1);
    step(); clear_in();
    chk_eq("R1", "inflight after group", int'(inflight_o), 4);
    chk_port("R2", 2, 1, 11);
    chk_port("R2", 3, 1, 12);
    chk_port("R2", 4, 1, 13);
    chk_port("R2", 1, 1, 14);
    chk_port("R2", 0, 0, 0);
    chk_port("R2", 5, 0, 0);
    step();
    chk_eq("R7", "no reissue", int'(issue_valid_o), 0);
    do_flush();
  endtask

  task automatic t_alu_pair();
    clear_in();
    set_op(0, 0, 21, 0, 1, 0, 1);
    set_op(1, 0, 22, 0, 1, 0, 1);
    set_op(2, 0, 23, 0, 1, 0, 1);
    step(); clear_in();
    chk_port("R3", 0, 1, 21);
    chk_port("R3", 5, 1, 22);
    step();
    chk_port("R3", 0, 1, 23);
    chk_port("R3", 5, 0, 0);
    step();
    chk_eq("R7", "alu drained", int'(issue_valid_o), 0);
    do_flush();
  endtask

  task automatic t_fp();
    clear_in();
    set_op(0, 2, 31, 0, 1, 0, 1);
    set_op(1, 2, 32, 0, 1, 0, 1);
    set_op(2, 2, 33, 0, 1, 0, 1);
    step(); clear_in();
    chk_port("R4", 0, 1, 31);
    chk_port("R4", 1, 1, 32);
    chk_port("R4", 5, 1, 33);
    set_op(0, 1, 34, 0, 1, 0, 1);
    set_op(1, 2, 35, 0, 1, 0, 1);
    step(); clear_in();
    chk_port("R4", 0, 1, 35);
    chk_port("R4", 1, 1, 34);
    chk_port("R4", 5, 0, 0);
    do_flush();
  endtask

  task automatic t_wake();
    clear_in();
    set_op(0, 0, 41, 10, 0, 12, 0);
    step(); clear_in();
    chk_port("R6", 0, 0, 0);
    wb_valid_i[0] = 1; wb_tag_i[0] = 10;
    wb_valid_i[1] = 1; wb_tag_i[1] = 99;
    step(); clear_in();
    chk_port("R6", 0, 0, 0);
    wb_valid_i[2] = 1; wb_tag_i[2] = 12;
    step(); clear_in();
    chk_port("R6", 0, 1, 41);
    step();
    chk_port("R7", 0, 0, 0);
    set_op(0, 0, 42, 11, 0, 0, 1);
    wb_valid_i[1] = 1; wb_tag_i[1] = 11;
    step(); clear_in();
    chk_port("R6", 0, 1, 42);
    do_flush();
  endtask

  task automatic t_age();
    clear_in();
    set_op(3, 0, 51, 20, 0, 0, 1);
    step(); clear_in();
    set_op(0, 0, 52, 20, 0, 0, 1);
    set_op(1, 0, 53, 20, 0, 0, 1);
    step(); clear_in();
    chk_eq("R5", "waiting no issue", int'(issue_valid_o), 0);
    wb_valid_i[1] = 1; wb_tag_i[1] = 20;
    step(); clear_in();
    chk_port("R5", 0, 1, 51);
    chk_port("R5", 5, 1, 52);
    step();
    chk_port("R5", 0, 1, 53);
    chk_port("R5", 5, 0, 0);
    do_flush();
  endtask

  task automatic t_full();
    clear_in();
    for (int k = 0; k < 4; k++) set_op(k, 0, 60 + k, 50, 0, 0, 1);
    for (int g = 0; g < 7; g++) step();
    chk_eq("R8", "stall with 4 free", int'(stall_o), 0);
    step();
    chk_eq("R8", "stall when full", int'(stall_o), 1);
    chk_eq("R1", "inflight full", int'(inflight_o), 32);
    clear_in();
    set_op(0, 3, 70, 0, 1, 0, 1);
    step(); clear_in();
    chk_port("R8", 2, 0, 0);
    chk_eq("R8", "ignored inflight", int'(inflight_o), 32);
    do_flush();
    chk_eq("R10", "flush inflight", int'(inflight_o), 0);
    chk_eq("R10", "flush stall", int'(stall_o), 0);
    wb_valid_i[0] = 1; wb_tag_i[0] = 50;
    step(); clear_in();
    chk_eq("R10", "flushed no issue", int'(issue_valid_o), 0);
  endtask

  task automatic t_limit();
    clear_in();
    set_op(0, 3, 1, 0, 1, 0, 1);
    set_op(1, 4, 2, 0, 1, 0, 1);
    set_op(2, 5, 3, 0, 1, 0, 1);
    set_op(3, 1, 4, 0, 1, 0, 1);
    for (int g = 0; g < 31; g++) step();
    chk_eq("R9", "inflight 124", int'(inflight_o), 124);
    chk_eq("R8", "no stall at 124", int'(stall_o), 0);
    step();
    chk_eq("R9", "inflight 128", int'(inflight_o), 128);
    chk_eq("R8", "stall at 128", int'(stall_o), 1);
    step();
    chk_eq("R8", "held inflight", int'(inflight_o), 128);
    chk_eq("R8", "held group not issued", int'(issue_valid_o), 0);
    clear_in(); retire_cnt_i = 4;
    step(); clear_in();
    chk_eq("R9", "retire 4", int'(inflight_o), 124);
    chk_eq("R8", "stall released", int'(stall_o), 0);
    set_op(0, 3, 5, 0, 1, 0, 1);
    step(); clear_in();
    chk_eq("R9", "inflight 125", int'(inflight_o), 125);
    chk_eq("R8", "stall at 125", int'(stall_o), 1);
    chk_port("R2", 2, 1, 5);
    retire_cnt_i = 3;
    step(); clear_in();
    chk_eq("R9", "retire 3", int'(inflight_o), 122);
    do_flush();
  endtask

  initial begin
    clear_in();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    t_reset();
    t_dedicated();
    t_alu_pair();
    t_fp();
    t_wake();
    t_age();
    t_full();
    t_limit();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule